// File: doc/BRIEF.md
# Switch Port Link Poller

This block keeps the port override settings of a small Ethernet switch in step with what each port's PHY reports. A single poll pulse starts a scan over the configured ports in ascending index order. For each port that is in use and not pinned to a fixed link, the block reads the PHY's management registers one at a time through a request/acknowledge port. It then decides whether the link has come up, gone down, or stayed the same.

The block acts only when a port's link state changes. On a change it emits one update carrying the port index, an override byte and a traffic-control byte, and it records the new state in its per-port link table. For a link that comes up, speed and duplex come from the autonegotiation registers. When the PHY reports extended status, the gigabit control and status registers are also consulted. A done pulse marks the end of the scan.

Management registers used: basic status = 1 (link bit 2, extended-status bit 8), advertisement = 4, partner ability = 5, gigabit control = 9, gigabit status = 10.

Top module: `lps_link_poller`

## Requirements
- R1: The basic status register is read twice back to back for every polled port, and only the second value is acted on, so a stale latched link-down seen in the first read is discarded.
- R2: A second status value of 0xFFFF marks the PHY as absent. The port is left with no update and no further reads, and its stored link state is kept.
- R3: When the link bit (status bit 2) equals the port's stored link state, no update is emitted and no further registers are read for that port.
- R4: On a change to link down, the update carries override byte 0x40 and traffic-control byte 0x03 (bit 0 receive off, bit 1 transmit off).
- R5: On a change to link up, the common modes are advertisement AND partner ability, taken from bits 9..6. The first set mode wins in this order: bit 8 (100 full), bit 9 (100 four-pair), bit 7 (100 half), bit 6 (10 full), else 10 half. Duplex is full only for bit 8 or bit 6. Speed is 100 only for bit 8 or bit 7, otherwise 10.
- R6: If status bit 8 is set, registers 9 and 10 are also read. If register 9 has bit 8 or 9 set and register 10 has bit 10 or 11 set, speed becomes 1000 and duplex is register 10 bit 11. Without status bit 8, neither register is read.
- R7: The override byte on a link-up update has bit 6 (enable) and bit 0 (link) set. Bit 1 is full duplex, bit 2 is 100 Mb/s and bit 3 is 1000 Mb/s, at most one speed bit is set, and the traffic-control byte is 0x00.
- R8: Every management request for a port with index EXT_FIRST (default 4) or higher has the external-bus select high; requests for lower ports have it low.
- R9: Ports whose in-use bit is low, or whose bypass bit is high, get no management reads and no updates.
- R10: After reset every stored link state is down, so the first scan emits a link-up update for every polled port whose PHY reports link.
- R11: Only one management request is open at a time. While the request is high and not acknowledged, its PHY and register address stay constant.
- R12: A poll pulse in idle starts a scan at port 0. done_o is a single-cycle pulse, issued once per scan after the last port has been handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_i | input | 1 | Start-of-scan pulse |
| port_used_i | input | 8 | Per-port in-use flags |
| port_bypass_i | input | 8 | Per-port fixed-link flags (not polled) |
| phy_addr_i | input | 40 | Per-port 5-bit PHY address, port n at bits 5n+4..5n |
| mdio_req_o | output | 1 | Management read request |
| mdio_ext_o | output | 1 | External management bus select |
| mdio_phy_o | output | 5 | PHY address of the request |
| mdio_reg_o | output | 5 | Register address of the request |
| mdio_ack_i | input | 1 | One-cycle acknowledge, read data valid |
| mdio_rdata_i | input | 16 | Read data |
| upd_valid_o | output | 1 | One-cycle update strobe |
| upd_port_o | output | 3 | Port index of the update |
| upd_ovr_o | output | 8 | Port override byte |
| upd_tc_o | output | 8 | Port traffic-control byte |
| done_o | output | 1 | End-of-scan pulse |

## Verification
A corrupted entry in the per-port link table shows up at the very next scan of that port. It appears either as a spurious update for a port whose PHY has not changed, or as a missing update after a real change. Both are visible within one poll. A wrong read step shows at the management port in the same transaction, as a wrong register address or an extra or missing gigabit read. A mis-resolved mode appears in the override byte of the update that ends that port's handling. The directed scans cover each resolution path, absent and skipped ports, and both link edges, so that each of these faults surfaces within one or two scans.

// File: rtl/lps_pkg.sv
package lps_pkg;
   localparam int RA_W = 5;

   localparam logic [RA_W-1:0] RA_STAT  = 5'd1;
   localparam logic [RA_W-1:0] RA_ADV   = 5'd4;
   localparam logic [RA_W-1:0] RA_LPA   = 5'd5;
   localparam logic [RA_W-1:0] RA_GCTL  = 5'd9;
   localparam logic [RA_W-1:0] RA_GSTAT = 5'd10;

   localparam int BIT_LINK = 2;
   localparam int BIT_XST  = 8;

   localparam logic [7:0] OVR_DOWN = 8'h40;
   localparam logic [7:0] TC_OFF   = 8'h03;
   localparam logic [7:0] TC_ON    = 8'h00;

   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_REQ, ST_EMIT} lps_state_e;
   typedef enum logic [2:0] {RD_STAT0, RD_STAT1, RD_ADV, RD_LPA, RD_GCTL, RD_GSTAT} lps_step_e;

   function automatic logic [RA_W-1:0] step_reg(lps_step_e s);
      case (s)
         RD_STAT0, RD_STAT1: step_reg = RA_STAT;
         RD_ADV:             step_reg = RA_ADV;
         RD_LPA:             step_reg = RA_LPA;
         RD_GCTL:            step_reg = RA_GCTL;
         default:            step_reg = RA_GSTAT;
      endcase
   endfunction
endpackage

// File: rtl/lps_resolve.sv
// Mode resolution. Ability bits as captured: [0]=10 full, [1]=100 half,
// [2]=100 full, [3]=100 four-pair. Gigabit: gctl [0]=half,[1]=full;
// gstat [0]=partner half, [1]=partner full.
module lps_resolve (
   input  logic [3:0] adv_i,
   input  logic [3:0] lpa_i,
   input  logic       gig_chk_i,
   input  logic [1:0] gctl_i,
   input  logic [1:0] gstat_i,
   output logic [7:0] ovr_o
);
   logic [3:0] common;
   logic       full, s100, s1000;

   always_comb begin
      common = adv_i & lpa_i;
      full   = 1'b0;
      s100   = 1'b0;
      if (common[2]) begin
         full = 1'b1;
         s100 = 1'b1;
      end else if (common[3]) begin
         full = 1'b0;
      end else if (common[1]) begin
         s100 = 1'b1;
      end else if (common[0]) begin
         full = 1'b1;
      end
      s1000 = gig_chk_i && (|gctl_i) && (|gstat_i);
      if (s1000) full = gstat_i[1];
      ovr_o = {1'b0, 1'b1, 2'b00, s1000, s100 && !s1000, full, 1'b1};
   end
endmodule

// File: rtl/lps_link_tbl.sv
module lps_link_tbl #(
   parameter int NUM_PORTS = 8,
   localparam int PORT_W = $clog2(NUM_PORTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [PORT_W-1:0] wr_port_i,
   input  logic              wr_val_i,
   input  logic [PORT_W-1:0] rd_port_i,
   output logic              rd_val_o
);
   logic [NUM_PORTS-1:0] state_q;

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            state_q[g] <= 1'b0;
         else if (wr_en_i && (wr_port_i == PORT_W'(g)))
            state_q[g] <= wr_val_i;
      end
   end

   assign rd_val_o = state_q[rd_port_i];
endmodule

// File: rtl/lps_link_poller.sv
module lps_link_poller
   import lps_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int EXT_FIRST = 4,
   parameter int PHY_AW    = 5,
   parameter bit GIG_EN    = 1'b1,
   localparam int PORT_W   = $clog2(NUM_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        poll_i,
   input  logic [NUM_PORTS-1:0]        port_used_i,
   input  logic [NUM_PORTS-1:0]        port_bypass_i,
   input  logic [NUM_PORTS*PHY_AW-1:0] phy_addr_i,
   output logic                        mdio_req_o,
   output logic                        mdio_ext_o,
   output logic [PHY_AW-1:0]           mdio_phy_o,
   output logic [RA_W-1:0]             mdio_reg_o,
   input  logic                        mdio_ack_i,
   input  logic [15:0]                 mdio_rdata_i,
   output logic                        upd_valid_o,
   output logic [PORT_W-1:0]           upd_port_o,
   output logic [7:0]                  upd_ovr_o,
   output logic [7:0]                  upd_tc_o,
   output logic                        done_o
);
   localparam logic [PORT_W-1:0] LAST_P = PORT_W'(NUM_PORTS - 1);
   localparam logic [PORT_W:0]   EXT_L  = EXT_FIRST[PORT_W:0];

   if (NUM_PORTS < 2 || EXT_FIRST > NUM_PORTS || PHY_AW < 1) begin : g_bad_cfg
      $error("lps_link_poller: illegal parameter set");
   end

   logic [PHY_AW-1:0] phy_tbl [NUM_PORTS];
   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_phy
      assign phy_tbl[g] = phy_addr_i[g*PHY_AW +: PHY_AW];
   end

   lps_state_e        state_q;
   lps_step_e         step_q;
   logic [PORT_W-1:0] port_q;
   logic              link_q, gig_q;
   logic [3:0]        adv_q, lpa_q;
   logic [1:0]        gctl_q, gstat_q;
   logic              link_now, skip, st_drop, go_next;
   logic [7:0]        ovr_up;

   lps_link_tbl #(.NUM_PORTS(NUM_PORTS)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (state_q == ST_EMIT),
      .wr_port_i (port_q),
      .wr_val_i  (link_q),
      .rd_port_i (port_q),
      .rd_val_o  (link_now)
   );

   lps_resolve u_res (
      .adv_i     (adv_q),
      .lpa_i     (lpa_q),
      .gig_chk_i (gig_q),
      .gctl_i    (gctl_q),
      .gstat_i   (gstat_q),
      .ovr_o     (ovr_up)
   );

   always_comb begin
      skip    = !port_used_i[port_q] || port_bypass_i[port_q];
      st_drop = (mdio_rdata_i == 16'hFFFF) || (mdio_rdata_i[BIT_LINK] == link_now);
      go_next = ((state_q == ST_SCAN) && skip)
             || ((state_q == ST_REQ) && mdio_ack_i && (step_q == RD_STAT1) && st_drop)
             || (state_q == ST_EMIT);
   end

   assign mdio_req_o = (state_q == ST_REQ);
   assign mdio_ext_o = ({1'b0, port_q} >= EXT_L);
   assign mdio_phy_o = phy_tbl[port_q];
   assign mdio_reg_o = step_reg(step_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         step_q      <= RD_STAT0;
         port_q      <= '0;
         link_q      <= 1'b0;
         gig_q       <= 1'b0;
         adv_q       <= '0;
         lpa_q       <= '0;
         gctl_q      <= '0;
         gstat_q     <= '0;
         upd_valid_o <= 1'b0;
         upd_port_o  <= '0;
         upd_ovr_o   <= '0;
         upd_tc_o    <= '0;
         done_o      <= 1'b0;
      end else begin
         upd_valid_o <= 1'b0;
         done_o      <= 1'b0;
         case (state_q)
            ST_IDLE: if (poll_i) begin
               port_q  <= '0;
               state_q <= ST_SCAN;
            end
            ST_SCAN: if (!skip) begin
               step_q  <= RD_STAT0;
               state_q <= ST_REQ;
            end
            ST_REQ: if (mdio_ack_i) begin
               case (step_q)
                  RD_STAT0: step_q <= RD_STAT1;
                  RD_STAT1: if (!st_drop) begin
                     link_q <= mdio_rdata_i[BIT_LINK];
                     gig_q  <= mdio_rdata_i[BIT_XST] && GIG_EN;
                     if (mdio_rdata_i[BIT_LINK]) step_q  <= RD_ADV;
                     else                        state_q <= ST_EMIT;
                  end
                  RD_ADV: begin
                     adv_q  <= mdio_rdata_i[9:6];
                     step_q <= RD_LPA;
                  end
                  RD_LPA: begin
                     lpa_q <= mdio_rdata_i[9:6];
                     if (gig_q) step_q  <= RD_GCTL;
                     else       state_q <= ST_EMIT;
                  end
                  RD_GCTL: begin
                     gctl_q <= mdio_rdata_i[9:8];
                     step_q <= RD_GSTAT;
                  end
                  default: begin
                     gstat_q <= mdio_rdata_i[11:10];
                     state_q <= ST_EMIT;
                  end
               endcase
            end
            default: begin
               upd_valid_o <= 1'b1;
               upd_port_o  <= port_q;
               upd_ovr_o   <= link_q ? ovr_up : OVR_DOWN;
               upd_tc_o    <= link_q ? TC_ON : TC_OFF;
            end
         endcase
         if (go_next) begin
            if (port_q == LAST_P) begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end else begin
               port_q  <= port_q + 1'b1;
               state_q <= ST_SCAN;
            end
         end
      end
   end
endmodule

// File: rtl/lps_link_poller_chk.sv
module lps_link_poller_chk #(
   parameter int PHY_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mdio_req,
   input logic              mdio_ack,
   input logic [PHY_AW-1:0] mdio_phy,
   input logic [4:0]        mdio_reg,
   input logic              upd_valid,
   input logic [7:0]        upd_ovr,
   input logic [7:0]        upd_tc,
   input logic              done
);
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_reg) && $stable(mdio_phy)));

   p_no_upd_in_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req |-> !upd_valid);

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mdio_req);

   p_down_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_ovr[0]) |-> (upd_ovr == 8'h40 && upd_tc == 8'h03));

   p_up_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_ovr[0]) |-> (upd_tc == 8'h00 && upd_ovr[6] && $countones(upd_ovr[3:2]) <= 1));
endmodule

bind lps_link_poller lps_link_poller_chk #(.PHY_AW(PHY_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mdio_req  (mdio_req_o),
   .mdio_ack  (mdio_ack_i),
   .mdio_phy  (mdio_phy_o),
   .mdio_reg  (mdio_reg_o),
   .upd_valid (upd_valid_o),
   .upd_ovr   (upd_ovr_o),
   .upd_tc    (upd_tc_o),
   .done      (done_o)
);

// File: tb/lps_link_poller_tb_top.sv
`timescale 1ns/1ps
module lps_link_poller_tb_top;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          poll = 1'b0;
   logic [NP-1:0] used, bypass;
   logic [NP*5-1:0] phy_addr;
   logic          mdio_req, mdio_ext, mdio_ack = 1'b0;
   logic [4:0]    mdio_phy, mdio_reg;
   logic [15:0]   mdio_rdata = '0;
   logic          upd_valid, done;
   logic [2:0]    upd_port;
   logic [7:0]    upd_ovr, upd_tc;

   always #2.5 clk = ~clk;

   lps_link_poller dut_i (
      .clk(clk), .rst_n(rst_n), .poll_i(poll),
      .port_used_i(used), .port_bypass_i(bypass), .phy_addr_i(phy_addr),
      .mdio_req_o(mdio_req), .mdio_ext_o(mdio_ext), .mdio_phy_o(mdio_phy),
      .mdio_reg_o(mdio_reg), .mdio_ack_i(mdio_ack), .mdio_rdata_i(mdio_rdata),
      .upd_valid_o(upd_valid), .upd_port_o(upd_port), .upd_ovr_o(upd_ovr),
      .upd_tc_o(upd_tc), .done_o(done)
   );

   int n_chk = 0, n_fail = 0;

   logic [15:0] m_stat [NP];
   logic [15:0] m_adv  [NP];
   logic [15:0] m_lpa  [NP];
   logic [15:0] m_gctl [NP];
   logic [15:0] m_gst  [NP];
   bit          m_latch[NP];
   int stat_rd[NP], tot_rd[NP], gig_rd[NP], upd_cnt[NP];
   logic [7:0]  last_ovr[NP], last_tc[NP];
   int done_cnt;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // PHY model behind the management port
   initial begin
      forever begin
         @(negedge clk);
         if (mdio_req && !mdio_ack) begin
            int p;
            logic [15:0] d;
            p = int'(mdio_phy) - 16;
            chk("R8 ext select", int'(mdio_ext), (p >= 4) ? 1 : 0);
            repeat (2) @(negedge clk);
            tot_rd[p]++;
            case (mdio_reg)
               5'd1: begin
                  stat_rd[p]++;
                  d = (m_latch[p] && (stat_rd[p] % 2 == 1)) ? (m_stat[p] & ~16'h0004) : m_stat[p];
               end
               5'd4: d = m_adv[p];
               5'd5: d = m_lpa[p];
               5'd9: begin gig_rd[p]++; d = m_gctl[p]; end
               default: begin gig_rd[p]++; d = m_gst[p]; end
            endcase
            mdio_rdata = d;
            mdio_ack = 1'b1;
            @(negedge clk);
            mdio_ack = 1'b0;
         end
      end
   end

   // update and done monitor
   initial begin
      forever begin
         @(negedge clk);
         if (upd_valid) begin
            upd_cnt[upd_port]++;
            last_ovr[upd_port] = upd_ovr;
            last_tc[upd_port]  = upd_tc;
         end
         if (done) done_cnt++;
      end
   end

   task automatic run_scan();
      for (int i = 0; i < NP; i++) begin
         stat_rd[i] = 0; tot_rd[i] = 0; gig_rd[i] = 0; upd_cnt[i] = 0;
      end
      done_cnt = 0;
      @(negedge clk) poll = 1'b1;
      @(negedge clk) poll = 1'b0;
      for (int t = 0; t < 3000 && done_cnt == 0; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R12 one done per scan", done_cnt, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 reset req", int'(mdio_req), 0);
      chk("R10 reset upd", int'(upd_valid), 0);
      chk("R12 reset done", int'(done), 0);
   endtask

   task automatic t_first_scan();
      run_scan();
      chk("R1 p0 status reads", stat_rd[0], 2);
      chk("R1 R10 p0 upd", upd_cnt[0], 1);
      chk("R5 p0 ovr 100F", last_ovr[0], 8'h47);
      chk("R7 p0 tc", last_tc[0], 8'h00);
      chk("R6 p0 no gig reads", gig_rd[0], 0);
      chk("R5 p1 ovr 10H", last_ovr[1], 8'h41);
      chk("R2 p2 absent upd", upd_cnt[2], 0);
      chk("R2 p2 reads", tot_rd[2], 2);
      chk("R9 p3 unused reads", tot_rd[3], 0);
      chk("R9 p3 unused upd", upd_cnt[3], 0);
      chk("R6 p4 ovr 1000F", last_ovr[4], 8'h4B);
      chk("R6 p4 gig reads", gig_rd[4], 2);
      chk("R6 p5 ovr 1000H", last_ovr[5], 8'h49);
      chk("R6 p6 no common gig", last_ovr[6], 8'h45);
      chk("R6 p6 gig reads", gig_rd[6], 2);
      chk("R9 p7 bypass reads", tot_rd[7], 0);
      chk("R9 p7 bypass upd", upd_cnt[7], 0);
   endtask

   task automatic t_steady();
      m_latch[0] = 1'b0;
      run_scan();
      for (int i = 0; i < NP; i++) chk("R3 no update when unchanged", upd_cnt[i], 0);
      chk("R3 p0 only status reads", tot_rd[0], 2);
   endtask

   task automatic t_down();
      m_stat[1] = 16'h7829;
      run_scan();
      chk("R4 p1 upd", upd_cnt[1], 1);
      chk("R4 p1 ovr", last_ovr[1], 8'h40);
      chk("R4 p1 tc", last_tc[1], 8'h03);
      chk("R4 p1 reads", tot_rd[1], 2);
      chk("R3 p0 quiet", upd_cnt[0], 0);
   endtask

   task automatic t_t4_and_late_phy();
      m_stat[1] = 16'h782D; m_adv[1] = 16'h0241; m_lpa[1] = 16'h0240;
      m_stat[2] = 16'h782D; m_adv[2] = 16'h0040; m_lpa[2] = 16'h0061;
      run_scan();
      chk("R5 p1 four-pair wins, 10 half", last_ovr[1], 8'h41);
      chk("R2 p2 now present upd", upd_cnt[2], 1);
      chk("R5 p2 10 full", last_ovr[2], 8'h43);
      chk("R7 p2 tc", last_tc[2], 8'h00);
   endtask

   task automatic t_gig_down();
      m_stat[4] = 16'h7929 & ~16'h0004;
      run_scan();
      chk("R4 p4 ovr", last_ovr[4], 8'h40);
      chk("R4 p4 tc", last_tc[4], 8'h03);
      chk("R6 p4 no gig reads when down", gig_rd[4], 0);
   endtask

   initial begin
      used   = 8'b1111_0111;
      bypass = 8'b1000_0000;
      for (int i = 0; i < NP; i++) begin
         phy_addr[i*5 +: 5] = 5'(16 + i);
         m_stat[i] = 16'h782D; m_adv[i] = 16'h01E0; m_lpa[i] = 16'h01E0;
         m_gctl[i] = 16'h0000; m_gst[i] = 16'h0000; m_latch[i] = 1'b0;
         last_ovr[i] = '0; last_tc[i] = '0;
      end
      m_latch[0] = 1'b1;
      m_adv[1] = 16'h0021; m_lpa[1] = 16'h0021;
      m_stat[2] = 16'hFFFF;
      m_stat[4] = 16'h792D; m_gctl[4] = 16'h0200; m_gst[4] = 16'h0800;
      m_stat[5] = 16'h792D; m_gctl[5] = 16'h0300; m_gst[5] = 16'h0400;
      m_stat[6] = 16'h792D; m_gctl[6] = 16'h0300; m_gst[6] = 16'h0000;
      m_adv[6] = 16'h0080; m_lpa[6] = 16'h0180;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_first_scan();
      t_steady();
      t_down();
      t_t4_and_late_phy();
      t_gig_down();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule